// File: doc/BRIEF.md
# Return Address Stack with Fill Watermark Interrupt

This block is a hardware last-in first-out store for return addresses. The sequencer pushes one word when it enters an interrupt handler or a subroutine and pops one word when it returns, so nested handlers and calls unwind in the right order without any software bookkeeping. The current top entry is always visible on `top_o`. The number of occupied entries is always visible on `fill_o`.

A registered level interrupt watches the fill count against two watermarks. The first sits near empty and the second near full. The interrupt stays high while the count is below the low mark or above the high mark. Software can then spill entries to memory before the stack overflows, or refill it before it runs dry.

Hard faults are recorded in two sticky flags: a push into a full stack and a pop from an empty one. Both flags stay set until reset. A push and a pop in the same cycle swap the top entry in place.

Top module: `rastk_top`

## Requirements
- R1: The stack holds up to DEPTH (default 33) entries. `fill_o` counts occupied entries from 0 to DEPTH. A lone push on a stack that is not full adds one to `fill_o` on the next clock edge.
- R2: Entries leave in reverse order of arrival. After a push, `top_o` shows the pushed word. After a lone pop on a non-empty stack, `fill_o` drops by one and `top_o` shows the entry that was below the popped one.
- R3: `lvl_irq_o` is 1 whenever `fill_o` is below LOW_MARK (default 3), that is, for counts 0, 1 and 2.
- R4: `lvl_irq_o` is 1 whenever `fill_o` is above HIGH_MARK (default 28), that is, for counts 29 to 33. It is 0 for counts 3 to 28.
- R5: `lvl_irq_o` is a register that changes on the same clock edge as `fill_o`, so the two outputs always agree with the R3 and R4 window.
- R6: A lone push while `fill_o` equals DEPTH discards the word. `fill_o` and `top_o` stay unchanged, and `ovf_o` becomes 1 on the next edge.
- R7: A lone pop while the stack is empty leaves `fill_o` at 0 and sets `unf_o` on the next edge. `top_o` reads 0 whenever `fill_o` is 0.
- R8: A push and a pop in the same cycle on a non-empty stack overwrite the top entry with the pushed word and leave `fill_o` unchanged. This also holds when the stack is full, and it does not set `ovf_o`.
- R9: A push and a pop in the same cycle on an empty stack set `unf_o`, discard the word and leave `fill_o` at 0.
- R10: While `rst_n` is low (asynchronous, active low), `fill_o` is 0, `top_o` is 0, `ovf_o` and `unf_o` are 0, and `lvl_irq_o` is 1 (the empty count lies below the low mark).
- R11: Once set, `ovf_o` and `unf_o` stay 1 through any later pushes and pops until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe (one word per cycle) |
| pop_i | input | 1 | Pop strobe (one word per cycle) |
| push_data_i | input | WIDTH | Return address to push |
| top_o | output | WIDTH | Current top entry, 0 when empty |
| fill_o | output | $clog2(DEPTH+1) | Number of occupied entries |
| lvl_irq_o | output | 1 | Level interrupt, high outside the watermark window |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its default parameters: WIDTH 16, DEPTH 33, LOW_MARK 3 and HIGH_MARK 28. With these values, a complete fill from empty to full takes only 33 pushes, followed by a complete drain. That walk crosses both watermark edges in each direction (counts 2 to 3 and 28 to 29) and reaches the overflow and full-stack swap corners. The drain then runs down to the underflow corner. Sixteen-bit words are wide enough to give each entry a distinct value, so any ordering error in the last-in first-out sequence shows up on `top_o`.

// File: rtl/rastk_pkg.sv
package rastk_pkg;

    // Operation chosen for one cycle from the two strobes and the fill state.
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_OVF,
        OP_UNF
    } op_e;

    function automatic op_e classify(input logic push,
                                     input logic pop,
                                     input logic empty,
                                     input logic full);
        op_e res;
        if (push && pop) begin
            res = empty ? OP_UNF : OP_SWAP;
        end else if (push) begin
            res = full ? OP_OVF : OP_PUSH;
        end else if (pop) begin
            res = empty ? OP_UNF : OP_POP;
        end else begin
            res = OP_HOLD;
        end
        return res;
    endfunction

endpackage

// File: rtl/rastk_ctrl.sv
module rastk_ctrl
    import rastk_pkg::*;
#(
    parameter int DEPTH = 33,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [CNTW-1:0] cnt_q,
    output logic [CNTW-1:0] cnt_d,
    output logic            ovf_q,
    output logic            unf_q,
    output logic            wr_en,
    output logic [CNTW-1:0] wr_idx
);

    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            ovf;
        logic            unf;
    } ctl_t;

    ctl_t st_d, st_q;
    op_e  op;

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = st_q.cnt;
        op     = classify(push, pop, st_q.cnt == '0, st_q.cnt == FULL_CNT);
        unique case (op)
            OP_PUSH: begin
                wr_en    = 1'b1;
                wr_idx   = st_q.cnt;
                st_d.cnt = st_q.cnt + 1'b1;
            end
            OP_POP: begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            OP_SWAP: begin
                wr_en  = 1'b1;
                wr_idx = st_q.cnt - 1'b1;
            end
            OP_OVF: begin
                st_d.ovf = 1'b1;
            end
            OP_UNF: begin
                st_d.unf = 1'b1;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;
    assign ovf_q = st_q.ovf;
    assign unf_q = st_q.unf;

endmodule

// File: rtl/rastk_mark.sv
module rastk_mark #(
    parameter int CNTW      = 6,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] cnt_d,
    output logic            irq_q
);

    localparam logic [CNTW-1:0] LOW_C  = CNTW'(LOW_MARK);
    localparam logic [CNTW-1:0] HIGH_C = CNTW'(HIGH_MARK);
    // The empty count decides the value held during reset.
    localparam logic IRQ_RST = (LOW_MARK > 0);

    logic irq_d;

    always_comb begin
        irq_d = (cnt_d < LOW_C) || (cnt_d > HIGH_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= IRQ_RST;
        end else begin
            irq_q <= irq_d;
        end
    end

endmodule

// File: rtl/rastk_mem.sv
module rastk_mem #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 33,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [CNTW-1:0]  wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [CNTW-1:0]  cnt_q,
    output logic [WIDTH-1:0] top
);

    logic [WIDTH-1:0] ent_d [DEPTH];
    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [DEPTH-1:0] we;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign we[g] = wr_en && (wr_idx == CNTW'(g));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = we[i] ? wr_data : ent_q[i];
        end
    end

    // Entries carry no reset: an entry is read only after it was written.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_q[i] <= ent_d[i];
        end
    end

    // AND-OR read of the slot just below the fill count; zero when empty.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNTW'(i + 1)) begin
                top = ent_q[i];
            end
        end
    end

endmodule

// File: rtl/rastk_top.sv
module rastk_top #(
    parameter int WIDTH     = 16,
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    localparam int CNTW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] top_o,
    output logic [CNTW-1:0]  fill_o,
    output logic             lvl_irq_o,
    output logic             ovf_o,
    output logic             unf_o
);

    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] cnt_d;
    logic            wr_en;
    logic [CNTW-1:0] wr_idx;

    rastk_ctrl #(
        .DEPTH (DEPTH),
        .CNTW  (CNTW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push_i),
        .pop    (pop_i),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d),
        .ovf_q  (ovf_o),
        .unf_q  (unf_o),
        .wr_en  (wr_en),
        .wr_idx (wr_idx)
    );

    rastk_mark #(
        .CNTW      (CNTW),
        .LOW_MARK  (LOW_MARK),
        .HIGH_MARK (HIGH_MARK)
    ) u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_d (cnt_d),
        .irq_q (lvl_irq_o)
    );

    rastk_mem #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .CNTW  (CNTW)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data_i),
        .cnt_q   (cnt_q),
        .top     (top_o)
    );

    assign fill_o = cnt_q;

endmodule

// File: rtl/rastk_chk.sv
module rastk_chk #(
    parameter int WIDTH     = 16,
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    parameter int CNTW      = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] push_data_i,
    input logic [WIDTH-1:0] top_o,
    input logic [CNTW-1:0]  fill_o,
    input logic             lvl_irq_o,
    input logic             ovf_o,
    input logic             unf_o
);

    localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] LOW_C  = CNTW'(LOW_MARK);
    localparam logic [CNTW-1:0] HIGH_C = CNTW'(HIGH_MARK);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= FULL_C); // R1

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && fill_o != FULL_C) |=> (fill_o == $past(fill_o) + 1'b1)); // R1

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && fill_o != FULL_C) |=> (top_o == $past(push_data_i))); // R2

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && fill_o != '0) |=> (fill_o == $past(fill_o) - 1'b1)); // R2

    AST_IRQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_irq_o == ((fill_o < LOW_C) || (fill_o > HIGH_C))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && fill_o == FULL_C) |=> (ovf_o && $stable(fill_o) && $stable(top_o))); // R6

    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && fill_o == '0) |=> (unf_o && fill_o == '0)); // R7

    AST_EMPTY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == '0) |-> (top_o == '0)); // R7

    AST_SWAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && fill_o != '0) |=> ($stable(fill_o) && top_o == $past(push_data_i))); // R8

    AST_SWAP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !ovf_o) |=> !ovf_o); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R11

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o); // R11

endmodule

bind rastk_top rastk_chk #(
    .WIDTH     (WIDTH),
    .DEPTH     (DEPTH),
    .LOW_MARK  (LOW_MARK),
    .HIGH_MARK (HIGH_MARK),
    .CNTW      (CNTW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_data_i (push_data_i),
    .top_o       (top_o),
    .fill_o      (fill_o),
    .lvl_irq_o   (lvl_irq_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
);

// File: tb/sim_rastk_top.sv
`timescale 1ns/1ps
module sim_rastk_top;

    localparam int W    = 16;
    localparam int D    = 33;
    localparam int LOW  = 3;
    localparam int HIGH = 28;
    localparam int CW   = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [W-1:0]  push_data_i = '0;
    logic [W-1:0]  top_o;
    logic [CW-1:0] fill_o;
    logic          lvl_irq_o;
    logic          ovf_o;
    logic          unf_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rastk_top #(
        .WIDTH     (W),
        .DEPTH     (D),
        .LOW_MARK  (LOW),
        .HIGH_MARK (HIGH)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .top_o       (top_o),
        .fill_o      (fill_o),
        .lvl_irq_o   (lvl_irq_o),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    typedef struct packed {
        logic          push;
        logic          pop;
        logic [15:0]   data;
        logic [5:0]    fill;
        logic [15:0]   top;
        logic          irq;
    } vec_t;

    // Walk from empty: grow to 3, swap, shrink, regrow, drain to empty.
    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b0, 16'h00A1, 6'd1, 16'h00A1, 1'b1},
        '{1'b1, 1'b0, 16'h00B2, 6'd2, 16'h00B2, 1'b1},
        '{1'b1, 1'b0, 16'h00C3, 6'd3, 16'h00C3, 1'b0},
        '{1'b1, 1'b1, 16'h00D4, 6'd3, 16'h00D4, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 6'd2, 16'h00B2, 1'b1},
        '{1'b0, 1'b0, 16'h0000, 6'd2, 16'h00B2, 1'b1},
        '{1'b1, 1'b0, 16'h00E5, 6'd3, 16'h00E5, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 6'd2, 16'h00B2, 1'b1},
        '{1'b0, 1'b1, 16'h0000, 6'd1, 16'h00A1, 1'b1},
        '{1'b0, 1'b1, 16'h0000, 6'd0, 16'h0000, 1'b1}
    };

    function automatic logic want_irq(input int n);
        return (n < LOW) || (n > HIGH);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic p, input logic q, input logic [W-1:0] d);
        push_i      = p;
        pop_i       = q;
        push_data_i = d;
        @(posedge clk);
        #1;
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " fill"}, 32'(fill_o), 32'd0);
        chk({tag, " top"},  32'(top_o), 32'd0);
        chk({tag, " ovf"},  32'(ovf_o), 32'd0);
        chk({tag, " unf"},  32'(unf_o), 32'd0);
        chk({tag, " irq"},  32'(lvl_irq_o), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("R10 power-on");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            op(TBL[i].push, TBL[i].pop, TBL[i].data);
            chk("R1 table fill", 32'(fill_o), 32'(TBL[i].fill));
            chk("R2 table top", 32'(top_o), 32'(TBL[i].top));
            chk("R3 table irq", 32'(lvl_irq_o), 32'(TBL[i].irq));
        end

        // Fill to the top; both watermark edges are crossed (R3, R4, R5)
        for (int k = 0; k < D; k++) begin
            op(1'b1, 1'b0, 16'(16'h1000 + k));
            chk("R1 fill grows", 32'(fill_o), 32'(k + 1));
            chk("R2 top after push", 32'(top_o), 32'(16'h1000 + k));
            chk("R4 R5 irq on fill", 32'(lvl_irq_o), 32'(want_irq(k + 1)));
        end
        chk("R6 no ovf before full push", 32'(ovf_o), 32'd0);

        // Push into a full stack
        op(1'b1, 1'b0, 16'hDEAD);
        chk("R6 ovf set", 32'(ovf_o), 32'd1);
        chk("R6 fill held", 32'(fill_o), 32'(D));
        chk("R6 data discarded", 32'(top_o), 32'h1020);
        chk("R6 unf clear", 32'(unf_o), 32'd0);

        // Swap at full
        op(1'b1, 1'b1, 16'hBEEF);
        chk("R8 swap at full fill", 32'(fill_o), 32'(D));
        chk("R8 swap at full top", 32'(top_o), 32'hBEEF);
        chk("R11 ovf stays", 32'(ovf_o), 32'd1);

        // Drain in reverse order
        for (int k = D - 1; k >= 0; k--) begin
            op(1'b0, 1'b1, '0);
            chk("R2 fill shrinks", 32'(fill_o), 32'(k));
            chk("R2 lifo order", 32'(top_o), (k == 0) ? 32'd0 : 32'(16'h1000 + k - 1));
            chk("R3 R5 irq on drain", 32'(lvl_irq_o), 32'(want_irq(k)));
        end

        // Pop from empty
        chk("R7 no unf yet", 32'(unf_o), 32'd0);
        op(1'b0, 1'b1, '0);
        chk("R7 unf set", 32'(unf_o), 32'd1);
        chk("R7 fill stays 0", 32'(fill_o), 32'd0);
        chk("R7 top zero", 32'(top_o), 32'd0);
        chk("R11 ovf still set", 32'(ovf_o), 32'd1);

        // Normal traffic does not clear the sticky flags
        op(1'b1, 1'b0, 16'h5555);
        chk("R11 push after fault fill", 32'(fill_o), 32'd1);
        chk("R11 push after fault top", 32'(top_o), 32'h5555);
        chk("R11 unf sticky", 32'(unf_o), 32'd1);
        chk("R11 ovf sticky", 32'(ovf_o), 32'd1);

        // Asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check_reset_state("R10 mid-run");
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // Push and pop together on an empty stack
        op(1'b1, 1'b1, 16'h7777);
        chk("R9 swap on empty unf", 32'(unf_o), 32'd1);
        chk("R9 swap on empty fill", 32'(fill_o), 32'd0);
        chk("R9 swap on empty top", 32'(top_o), 32'd0);
        chk("R9 swap on empty ovf", 32'(ovf_o), 32'd0);

        op(1'b1, 1'b0, 16'h1111);
        chk("R2 push after reset", 32'(top_o), 32'h1111);
        chk("R1 count after reset", 32'(fill_o), 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule